// File: doc/BRIEF.md
# Byte-Lane Static RAM Access Controller

This block sits between an on-chip requester and an external asynchronous static RAM of 131,072 words of 16 bits. The requester offers one access at a time on a valid/ready port: an address, a write flag, a write word and a two-bit lane mask. The controller turns each access into a timed sequence on the memory's active-low chip-select, output-enable, write-enable and per-byte strobes. Every pin is driven from a register, so the pins are free of glitches.

The length of each phase is a parameter counted in clock cycles: the write strobe width, a turnaround phase before output enable, and the access time before capture. Read data is registered once the access time has elapsed. It is returned with a single-cycle valid pulse, and lanes that were not requested read as zero. The bidirectional data bus is split into an output word, an output-enable and an input word. The controller's driver is on only during a write strobe, and it is off for at least one cycle before output enable is asserted.

For consecutive writes, write enable stays low after a write while the controller is idle. Each word's write is then opened and closed by the byte strobes together with chip select. Write enable rises only when a read begins.

Top module: `sramLaneCtrl`

## Requirements
- R1: While reset is held and on the first cycle after it, memCeN, memOeN, memWeN, memLbN and memUbN are 1, memDoutEn is 0, reqReady is 1 and rdValid is 0.
- R2: reqReady is 1 only while the controller is idle. A request is taken on a clock edge where reqValid and reqReady are both 1. A write keeps reqReady low for WR_CYC cycles.
- R3: For WR_CYC cycles after a write is taken: memCeN=0, memWeN=0, memOeN=1, memDoutEn=1, memAddr equals the request address (all 17 bits), and memDout equals the write word.
- R4: Mask bit 0 selects the lower byte (bits 7..0) and mask bit 1 selects the upper byte (bits 15..8). During a write, memLbN equals the inverse of mask bit 0 and memUbN equals the inverse of mask bit 1. A lane whose bit is 0 keeps its old contents.
- R5: A read first spends TURN_CYC cycles with memCeN=0, memWeN=1, memOeN=1 and memDoutEn=0, with the lane strobes set from the mask. It then spends RD_CYC cycles with memOeN=0.
- R6: Read data is captured at the edge that ends the last output-enable cycle. rdValid is 1 for exactly one cycle, and reqReady returns in that same cycle. A read of 11 returns the word last written.
- R7: On rdData, the byte of a lane whose mask bit is 0 is zero.
- R8: memDoutEn is 1 only while memWeN is 0 and memOeN is 1. memOeN is never 0 in a cycle that follows one with memDoutEn at 1.
- R9: After a write and while idle, memWeN stays 0 with memCeN, memLbN and memUbN at 1. memWeN rises only as a read begins.
- R10: While idle, memCeN, memOeN, memLbN and memUbN are 1 and memDoutEn is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Controller idle, request can be taken |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 17 | Word address |
| reqWdata | input | 16 | Write word |
| reqMask | input | 2 | Lane mask, bit 0 lower byte, bit 1 upper byte |
| rdValid | output | 1 | One-cycle pulse with read data |
| rdData | output | 16 | Read word, disabled lanes zero |
| memAddr | output | 17 | Memory address |
| memCeN | output | 1 | Chip select, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memLbN | output | 1 | Lower byte strobe, active low |
| memUbN | output | 1 | Upper byte strobe, active low |
| memDout | output | 16 | Data driven toward memory |
| memDoutEn | output | 1 | Data bus driver enable |
| memDin | input | 16 | Data returned from memory |

## Verification
The assertions assume that the phase parameters are at least one. They also assume that the request fields are steady whenever reqValid is high, because the controller samples them only on the edge that takes the request. The bench changes its inputs only on falling edges and drops reqValid in the cycle right after acceptance, so no request is ever offered twice. Its memory model drives only the lanes that are read-enabled and puts fixed garbage on the others, so zeroing of disabled lanes is actually exercised.

// File: rtl/sramLanePkg.sv
package sramLanePkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int DATA_W = LANE_W * LANES;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_WRITE = 2'd1,
    S_RDSET = 2'd2,
    S_RDACC = 2'd3
  } ctlState_t;

  // next-cycle intent handed from control to datapath
  typedef struct packed {
    logic load;     // capture request fields this edge
    logic sel;      // chip select active next cycle
    logic oe;       // output enable active next cycle
    logic we;       // write enable active next cycle
    logic lanes;    // lane strobes follow mask next cycle
    logic drive;    // bus driver on next cycle
    logic capture;  // register read word this edge
  } ctlStrobes_t;
endpackage

// File: rtl/sramLaneFsm.sv
module sramLaneFsm
  import sramLanePkg::*;
#(
  parameter int TURN_CYC = 1,
  parameter int RD_CYC   = 2,
  parameter int WR_CYC   = 1,
  parameter bit HOLD_WE  = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  input  logic        reqWrite,
  output logic        ready,
  output ctlStrobes_t ctl
);
  localparam int MAX_AB = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int MAXC   = (MAX_AB > TURN_CYC) ? MAX_AB : TURN_CYC;
  localparam int CNT_W  = (MAXC < 2) ? 1 : $clog2(MAXC);
  localparam logic [CNT_W-1:0] WR_LOAD   = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LOAD = CNT_W'(TURN_CYC - 1);

  ctlState_t        state, nxtState;
  logic [CNT_W-1:0] cnt, nxtCnt;
  logic             weHold, weHoldNxt;
  logic             loadNow, captureNow;

  always_comb begin
    nxtState   = state;
    nxtCnt     = cnt;
    loadNow    = 1'b0;
    captureNow = 1'b0;
    case (state)
      S_IDLE: begin
        if (reqValid) begin
          loadNow = 1'b1;
          if (reqWrite) begin
            nxtState = S_WRITE;
            nxtCnt   = WR_LOAD;
          end else begin
            nxtState = S_RDSET;
            nxtCnt   = TURN_LOAD;
          end
        end
      end
      S_WRITE: begin
        if (cnt == '0) nxtState = S_IDLE;
        else           nxtCnt   = cnt - 1'b1;
      end
      S_RDSET: begin
        if (cnt == '0) begin
          nxtState = S_RDACC;
          nxtCnt   = RD_LOAD;
        end else begin
          nxtCnt = cnt - 1'b1;
        end
      end
      S_RDACC: begin
        if (cnt == '0) begin
          nxtState   = S_IDLE;
          captureNow = 1'b1;
        end else begin
          nxtCnt = cnt - 1'b1;
        end
      end
      default: nxtState = S_IDLE;
    endcase
  end

  generate
    if (HOLD_WE) begin : gHold
      always_comb begin
        if (nxtState == S_WRITE)      weHoldNxt = 1'b1;
        else if (nxtState == S_RDSET) weHoldNxt = 1'b0;
        else                          weHoldNxt = weHold;
      end
    end else begin : gNoHold
      always_comb weHoldNxt = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state  <= S_IDLE;
      cnt    <= '0;
      weHold <= 1'b0;
    end else begin
      state  <= nxtState;
      cnt    <= nxtCnt;
      weHold <= weHoldNxt;
    end
  end

  always_comb begin
    ctl.load    = loadNow;
    ctl.capture = captureNow;
    ctl.sel     = (nxtState != S_IDLE);
    ctl.lanes   = (nxtState != S_IDLE);
    ctl.oe      = (nxtState == S_RDACC);
    ctl.drive   = (nxtState == S_WRITE);
    ctl.we      = (nxtState == S_WRITE) || ((nxtState == S_IDLE) && weHoldNxt);
  end

  assign ready = (state == S_IDLE);
endmodule

// File: rtl/sramLaneDatapath.sv
module sramLaneDatapath
  import sramLanePkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobes_t       ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  input  logic [DATA_W-1:0] memDin,
  output logic [ADDR_W-1:0] memAddr,
  output logic              ceN,
  output logic              oeN,
  output logic              weN,
  output logic [LANES-1:0]  laneN,
  output logic [DATA_W-1:0] dout,
  output logic              doutEn,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);
  logic [LANES-1:0]  maskQ, maskNow;
  logic [DATA_W-1:0] laneData;

  assign maskNow = ctl.load ? reqMask : maskQ;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      maskQ   <= '0;
      memAddr <= '0;
      dout    <= '0;
      ceN     <= 1'b1;
      oeN     <= 1'b1;
      weN     <= 1'b1;
      doutEn  <= 1'b0;
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      if (ctl.load) begin
        maskQ   <= reqMask;
        memAddr <= reqAddr;
        dout    <= reqWdata;
      end
      ceN     <= ~ctl.sel;
      oeN     <= ~ctl.oe;
      weN     <= ~ctl.we;
      doutEn  <= ctl.drive;
      rdValid <= ctl.capture;
      if (ctl.capture) rdData <= laneData;
    end
  end

  generate
    for (genvar g = 0; g < LANES; g++) begin : gLane
      always_ff @(posedge clk or posedge rst) begin
        if (rst) laneN[g] <= 1'b1;
        else     laneN[g] <= ~(ctl.lanes & maskNow[g]);
      end
      assign laneData[g*LANE_W +: LANE_W] =
        maskQ[g] ? memDin[g*LANE_W +: LANE_W] : '0;
    end
  endgenerate
endmodule

// File: rtl/sramLaneCtrl.sv
module sramLaneCtrl
  import sramLanePkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int TURN_CYC = 1,
  parameter int RD_CYC   = 2,
  parameter int WR_CYC   = 1,
  parameter bit HOLD_WE  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [15:0]       reqWdata,
  input  logic [1:0]        reqMask,
  output logic              rdValid,
  output logic [15:0]       rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic              memLbN,
  output logic              memUbN,
  output logic [15:0]       memDout,
  output logic              memDoutEn,
  input  logic [15:0]       memDin
);
  ctlStrobes_t      ctl;
  logic [LANES-1:0] laneN;

  sramLaneFsm #(
    .TURN_CYC(TURN_CYC),
    .RD_CYC  (RD_CYC),
    .WR_CYC  (WR_CYC),
    .HOLD_WE (HOLD_WE)
  ) fsm_i (
    .clk     (clk),
    .rst     (rst),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .ready   (reqReady),
    .ctl     (ctl)
  );

  sramLaneDatapath #(
    .ADDR_W(ADDR_W)
  ) dp_i (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .reqMask (reqMask),
    .memDin  (memDin),
    .memAddr (memAddr),
    .ceN     (memCeN),
    .oeN     (memOeN),
    .weN     (memWeN),
    .laneN   (laneN),
    .dout    (memDout),
    .doutEn  (memDoutEn),
    .rdValid (rdValid),
    .rdData  (rdData)
  );

  assign memLbN = laneN[0];
  assign memUbN = laneN[1];
endmodule

// File: rtl/sramLaneCtrlChk.sv
module sramLaneCtrlChk (
  input logic clk,
  input logic rst,
  input logic reqReady,
  input logic rdValid,
  input logic memCeN,
  input logic memOeN,
  input logic memWeN,
  input logic memLbN,
  input logic memUbN,
  input logic memDoutEn
);
  AST_RESET_INACTIVE: assert property (@(posedge clk)
    rst |=> (memCeN && memOeN && memWeN && memLbN && memUbN && !memDoutEn && !rdValid)); // R1

  AST_DRIVER_SAFE: assert property (@(posedge clk) disable iff (rst)
    memDoutEn |-> (!memWeN && memOeN)); // R8

  AST_OE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !memOeN |-> !$past(memDoutEn)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    reqReady |-> (memCeN && memOeN && memLbN && memUbN && !memDoutEn)); // R10

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    rdValid |=> !rdValid); // R6

  AST_VALID_READY: assert property (@(posedge clk) disable iff (rst)
    rdValid |-> reqReady); // R6

  AST_READ_NO_WE: assert property (@(posedge clk) disable iff (rst)
    !memOeN |-> (memWeN && !memCeN)); // R5

  AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!memWeN && !memCeN) |-> memOeN); // R3

  AST_WE_RISE_READ: assert property (@(posedge clk) disable iff (rst)
    $rose(memWeN) |-> (!memCeN && memOeN)); // R9
endmodule

bind sramLaneCtrl sramLaneCtrlChk chk_i (
  .clk      (clk),
  .rst      (rst),
  .reqReady (reqReady),
  .rdValid  (rdValid),
  .memCeN   (memCeN),
  .memOeN   (memOeN),
  .memWeN   (memWeN),
  .memLbN   (memLbN),
  .memUbN   (memUbN),
  .memDoutEn(memDoutEn)
);

// File: tb/sramLaneCtrl_tb_top.sv
module sramLaneCtrl_tb_top;
  localparam int TURN = 1;
  localparam int RDC  = 2;
  localparam int WRC  = 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqMask = '0;
  logic        reqReady, rdValid;
  logic [15:0] rdData;
  logic [16:0] memAddr;
  logic        memCeN, memOeN, memWeN, memLbN, memUbN, memDoutEn;
  logic [15:0] memDout, memDin;

  int errs = 0;
  int checks = 0;
  bit monOn = 1'b0;

  always #10 clk = ~clk;

  sramLaneCtrl #(.TURN_CYC(TURN), .RD_CYC(RDC), .WR_CYC(WRC)) dut_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqMask(reqMask), .rdValid(rdValid), .rdData(rdData),
    .memAddr(memAddr), .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN),
    .memLbN(memLbN), .memUbN(memUbN), .memDout(memDout),
    .memDoutEn(memDoutEn), .memDin(memDin)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------- behavioural memory device ----------
  logic [15:0] sramArr [0:1023];
  logic [15:0] rdWord;
  bit          prevLo = 0, prevHi = 0;
  logic [16:0] prevAddr;
  logic [15:0] prevData;
  initial for (int i = 0; i < 1024; i++) sramArr[i] = 16'h0000;

  always @* begin
    rdWord = sramArr[memAddr[9:0]];
    memDin = 16'hFFFF;
    if (!memCeN && memWeN && !memOeN) begin
      memDin[7:0]  = !memLbN ? rdWord[7:0]  : 8'h3C;
      memDin[15:8] = !memUbN ? rdWord[15:8] : 8'hA5;
    end
  end

  always @(negedge clk) begin
    bit curLo, curHi;
    curLo = !memCeN && !memWeN && !memLbN;
    curHi = !memCeN && !memWeN && !memUbN;
    if (prevLo && !curLo) sramArr[prevAddr[9:0]][7:0]  = prevData[7:0];
    if (prevHi && !curHi) sramArr[prevAddr[9:0]][15:8] = prevData[15:8];
    if (curLo || curHi) begin
      prevAddr = memAddr;
      prevData = memDout;
    end
    prevLo = curLo;
    prevHi = curHi;
  end

  // ---------- cycle reference model ----------
  logic [15:0] refMem [int];
  bit          expReady = 1'b1, expRdValid = 1'b0, pendRead = 1'b0;
  logic [15:0] expRdData = '0, pendData = '0;
  int          busy = 0;

  function automatic logic [15:0] refRead(input int a);
    return refMem.exists(a) ? refMem[a] : 16'h0000;
  endfunction

  always @(posedge clk) begin
    expRdValid = 1'b0;
    if (rst) begin
      expReady = 1'b1; busy = 0; pendRead = 1'b0;
    end else if (!expReady) begin
      busy--;
      if (busy == 0) begin
        expReady = 1'b1;
        if (pendRead) begin
          expRdValid = 1'b1; expRdData = pendData; pendRead = 1'b0;
        end
      end
    end else if (reqValid) begin
      logic [15:0] w;
      w = refRead(int'(reqAddr));
      expReady = 1'b0;
      if (reqWrite) begin
        if (reqMask[0]) w[7:0]  = reqWdata[7:0];
        if (reqMask[1]) w[15:8] = reqWdata[15:8];
        refMem[int'(reqAddr)] = w;
        busy = WRC;
      end else begin
        pendData = {reqMask[1] ? w[15:8] : 8'h00, reqMask[0] ? w[7:0] : 8'h00};
        pendRead = 1'b1;
        busy = TURN + RDC;
      end
    end
  end

  bit prevDrive = 1'b0;
  always @(negedge clk) begin
    if (monOn) begin
      chk(reqReady == expReady, "R2 ready", 32'(reqReady), 32'(expReady));
      chk(rdValid == expRdValid, "R6 rdValid", 32'(rdValid), 32'(expRdValid));
      if (expRdValid) chk(rdData == expRdData, "R6 rdData", 32'(rdData), 32'(expRdData));
      if (memDoutEn) chk(!memWeN && memOeN, "R8 drive", {memWeN, memOeN}, 32'h1);
      if (!memOeN) chk(!prevDrive, "R8 turnaround", 32'(prevDrive), 32'h0);
      if (reqReady) chk(memCeN && memOeN && memLbN && memUbN && !memDoutEn, "R10 idle",
                        {memCeN, memOeN, memLbN, memUbN, memDoutEn}, 32'h1E);
    end
    prevDrive = memDoutEn;
  end

  // ---------- stimulus ----------
  task automatic doReq(input bit wr, input logic [16:0] a, input logic [15:0] d, input logic [1:0] m);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqMask = m;
    @(negedge clk);
    reqValid = 1'b0;
    if (wr) begin
      chk(!memCeN && !memWeN && memOeN && memDoutEn, "R3 strobes",
          {memCeN, memWeN, memOeN, memDoutEn}, 32'h3);
      chk(memAddr == a && memDout == d, "R3 addr/data", {memAddr[15:0], memDout}, {a[15:0], d});
      chk(memLbN == !m[0] && memUbN == !m[1], "R4 lane strobes", {memUbN, memLbN}, 32'(~m));
    end else begin
      chk(!memCeN && memWeN && memOeN && !memDoutEn, "R5 setup",
          {memCeN, memWeN, memOeN, memDoutEn}, 32'h6);
      chk(memLbN == !m[0] && memUbN == !m[1], "R5 lanes", {memUbN, memLbN}, 32'(~m));
      @(negedge clk);
      chk(!memOeN && !memDoutEn, "R5 oe low", {memOeN, memDoutEn}, 32'h0);
    end
  endtask

  task automatic readExp(input logic [16:0] a, input logic [1:0] m, input logic [15:0] e, input string tag);
    doReq(1'b0, a, 16'h0, m);
    while (!rdValid) @(negedge clk);
    chk(rdData == e, tag, 32'(rdData), 32'(e));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    chk(memCeN && memOeN && memWeN && memLbN && memUbN && !memDoutEn && reqReady && !rdValid,
        "R1 in reset", {memCeN, memOeN, memWeN, memLbN, memUbN, memDoutEn, reqReady, rdValid}, 32'hFA);
    rst = 1'b0;
    @(negedge clk);
    chk(memCeN && memOeN && memWeN && memLbN && memUbN && !memDoutEn && reqReady && !rdValid,
        "R1 after reset", {memCeN, memOeN, memWeN, memLbN, memUbN, memDoutEn, reqReady, rdValid}, 32'hFA);
    monOn = 1'b1;

    doReq(1'b1, 17'd5, 16'h1234, 2'b11);
    readExp(17'd5, 2'b11, 16'h1234, "R6 full word");
    doReq(1'b1, 17'd5, 16'hABCD, 2'b01);
    readExp(17'd5, 2'b11, 16'h12CD, "R4 lower only");
    doReq(1'b1, 17'd5, 16'h99EE, 2'b10);
    doReq(1'b1, 17'd5, 16'h7777, 2'b00);
    readExp(17'd5, 2'b11, 16'h99CD, "R4 upper only, empty mask");
    readExp(17'd5, 2'b01, 16'h00CD, "R7 upper zeroed");
    readExp(17'd5, 2'b10, 16'h9900, "R7 lower zeroed");
    readExp(17'd5, 2'b00, 16'h0000, "R7 both zeroed");
    doReq(1'b1, 17'h10007, 16'hBEEF, 2'b11);
    readExp(17'h10007, 2'b11, 16'hBEEF, "R3 top address");

    // back-to-back writes with write enable held
    for (int i = 0; i < 4; i++) begin
      doReq(1'b1, 17'(32 + i), 16'h1100 + 16'(i * 17), (i % 2 == 0) ? 2'b11 : 2'b11);
      @(negedge clk); @(negedge clk);
      chk(!memWeN && memCeN && memLbN && memUbN, "R9 we held",
          {memWeN, memCeN, memLbN, memUbN}, 32'h7);
    end
    for (int i = 0; i < 4; i++)
      readExp(17'(32 + i), 2'b11, 16'h1100 + 16'(i * 17), "R9 readback");
    @(negedge clk);
    chk(memWeN, "R9 we released by read", 32'(memWeN), 32'h1);

    // pseudo-random mix compared against the reference model
    lfsr = 16'hACE1;
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      doReq(lfsr[0], 17'(64 + lfsr[6:1]), lfsr ^ 16'h5A5A, lfsr[8:7]);
    end
    repeat (8) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule